// File: doc/BRIEF.md
# Fractional Sawtooth Ramp Generator

This block produces a 12-bit ramp sample for one output channel. It keeps a 16-bit accumulator that holds a 12-bit integer part and a 4-bit fraction. Two kinds of trigger move the accumulator. A restart trigger loads a programmable 12-bit start level. An advance trigger adds or subtracts a programmable step. The step has a resolution of 1/16 of an output code, so slow ramps can be built without sub-sampling.

Each trigger kind has its own source select. A select of 0 means the trigger comes from a software request strobe. A select of k, where 1 ≤ k ≤ N_HW, means it comes from hardware line k-1. A software request made while its select is non-zero is refused, and an error flag pulses.

The sample output is a plain level that always shows the current integer part. It is not a stream, so it has no valid/ready handshake and no back-pressure. Consumers may sample it in any cycle.

Top module: `sawtooth_gen`

## Requirements
- R1: After reset is released, `sample` is 0, `rst_err` is 0 and `step_err` is 0.
- R2: A restart trigger in a cycle with `en`=1 sets the accumulator to {`rst_value`, 4'b0000}. `sample` shows `rst_value` after that clock edge.
- R3: An advance trigger with `step_dir`=0 adds `step_value` to the 16-bit accumulator, modulo 2^16. An integer part of 4095 plus one code wraps to 0.
- R4: An advance trigger with `step_dir`=1 subtracts `step_value` from the accumulator, modulo 2^16. An integer part of 0 minus one code wraps to 4095.
- R5: When a restart trigger and an advance trigger occur in the same enabled cycle, only the restart takes effect.
- R6: A software request (`sw_rst_req` or `sw_step_req`) acts only when its select is 0. With a non-zero select the request does not change the accumulator, and the matching error flag (`rst_err` or `step_err`) is 1 for exactly the following cycle.
- R7: A select value k, with 1 ≤ k ≤ N_HW, makes hardware line k-1 the only trigger source. Software requests and the other lines are then ignored. With select 0, all hardware lines are ignored.
- R8: While `en`=0, triggers do not change the accumulator. Error flags are still raised as in R6.
- R9: `sample` is accumulator bits [15:4]. A step of 0x0001 applied 16 times from a restart raises `sample` by exactly 1, on the 16th step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows triggers to update the accumulator |
| step_dir | input | 1 | Step direction: 0 adds, 1 subtracts |
| rst_value | input | 12 | Start level loaded by a restart |
| step_value | input | 16 | Unsigned step in 12.4 fixed point |
| rst_src | input | SEL_W | Restart source: 0 software, k hardware line k-1 |
| step_src | input | SEL_W | Advance source: 0 software, k hardware line k-1 |
| sw_rst_req | input | 1 | Software restart request strobe |
| sw_step_req | input | 1 | Software advance request strobe |
| hw_rst_trig | input | N_HW | Hardware restart trigger lines |
| hw_step_trig | input | N_HW | Hardware advance trigger lines |
| sample | output | 12 | Integer part of the accumulator |
| rst_err | output | 1 | Pulse: software restart request refused |
| step_err | output | 1 | Pulse: software advance request refused |

## Verification
The accumulator and both error flags are registered. A trigger or a refused request applied before a clock edge therefore shows on `sample` and on the error flags right after that edge, one cycle later. Nothing in the block adds more latency.

The bench drives every input on the falling edge and samples on the next falling edge. Each check therefore sees the result of exactly one rising edge. The bench's own 16-bit model is updated once per cycle from the same inputs, so expected values line up with that one-edge result.

// File: rtl/saw_pkg.sv
package saw_pkg;
  localparam int INT_W  = 12;
  localparam int FRAC_W = 4;
  localparam int ACC_W  = INT_W + FRAC_W;

  typedef logic [ACC_W-1:0] acc_t;
  typedef logic [INT_W-1:0] lvl_t;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

  function automatic acc_t acc_next(input acc_t cur, input acc_t stp, input dir_e d);
    return (d == DIR_UP) ? acc_t'(cur + stp) : acc_t'(cur - stp);
  endfunction
endpackage

// File: rtl/saw_trig_sel.sv
module saw_trig_sel #(
  parameter int N_HW  = 3,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] src,
  input  logic             sw_req,
  input  logic [N_HW-1:0]  hw_trig,
  output logic             fire,
  output logic             reject
);
  logic [N_HW-1:0] hit;

  for (genvar k = 0; k < N_HW; k++) begin : g_line
    assign hit[k] = hw_trig[k] && (src == SEL_W'(k + 1));
  end

  assign fire   = (src == '0) ? sw_req : |hit;
  assign reject = sw_req && (src != '0);
endmodule

// File: rtl/saw_accum.sv
module saw_accum
  import saw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic do_load,
  input  logic do_step,
  input  dir_e dir,
  input  lvl_t load_lvl,
  input  acc_t step,
  output acc_t acc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (en) begin
      if (do_load)
        acc_q <= {load_lvl, {FRAC_W{1'b0}}};
      else if (do_step)
        acc_q <= acc_next(acc_q, step, dir);
    end
  end
endmodule

// File: rtl/sawtooth_gen.sv
module sawtooth_gen
  import saw_pkg::*;
#(
  parameter int N_HW  = 3,
  parameter int SEL_W = $clog2(N_HW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               step_dir,
  input  logic [INT_W-1:0]   rst_value,
  input  logic [ACC_W-1:0]   step_value,
  input  logic [SEL_W-1:0]   rst_src,
  input  logic [SEL_W-1:0]   step_src,
  input  logic               sw_rst_req,
  input  logic               sw_step_req,
  input  logic [N_HW-1:0]    hw_rst_trig,
  input  logic [N_HW-1:0]    hw_step_trig,
  output logic [INT_W-1:0]   sample,
  output logic               rst_err,
  output logic               step_err
);
  logic rst_fire, rst_rej, step_fire, step_rej;
  acc_t acc_q;

  saw_trig_sel #(.N_HW(N_HW), .SEL_W(SEL_W)) u_rsel (
    .src(rst_src), .sw_req(sw_rst_req), .hw_trig(hw_rst_trig),
    .fire(rst_fire), .reject(rst_rej)
  );

  saw_trig_sel #(.N_HW(N_HW), .SEL_W(SEL_W)) u_ssel (
    .src(step_src), .sw_req(sw_step_req), .hw_trig(hw_step_trig),
    .fire(step_fire), .reject(step_rej)
  );

  saw_accum u_acc (
    .clk(clk), .rst_n(rst_n), .en(en),
    .do_load(rst_fire), .do_step(step_fire),
    .dir(dir_e'(step_dir)), .load_lvl(rst_value), .step(step_value),
    .acc_q(acc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_err  <= 1'b0;
      step_err <= 1'b0;
    end else begin
      rst_err  <= rst_rej;
      step_err <= step_rej;
    end
  end

  assign sample = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/saw_chk.sv
module saw_chk
  import saw_pkg::*;
#(
  parameter int N_HW  = 3,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             step_dir,
  input logic [INT_W-1:0] rst_value,
  input logic [ACC_W-1:0] step_value,
  input logic [SEL_W-1:0] rst_src,
  input logic [SEL_W-1:0] step_src,
  input logic             sw_rst_req,
  input logic             sw_step_req,
  input logic [INT_W-1:0] sample,
  input logic             rst_err,
  input logic             step_err,
  input logic [ACC_W-1:0] acc_q
);
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en && rst_src == '0 && sw_rst_req |=> sample == $past(rst_value)); // R2

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    en && step_src == '0 && sw_step_req && !step_dir && rst_src == '0 && !sw_rst_req
    |=> acc_q == ACC_W'($past(acc_q) + $past(step_value))); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    en && step_src == '0 && sw_step_req && step_dir && rst_src == '0 && !sw_rst_req
    |=> acc_q == ACC_W'($past(acc_q) - $past(step_value))); // R4

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sw_step_req && step_src != '0 |=> step_err); // R6

  AST_NO_FALSE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_rst_req && rst_src != '0) |=> !rst_err); // R6

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q)); // R8
endmodule

bind sawtooth_gen saw_chk #(.N_HW(N_HW), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .step_dir(step_dir),
  .rst_value(rst_value), .step_value(step_value),
  .rst_src(rst_src), .step_src(step_src),
  .sw_rst_req(sw_rst_req), .sw_step_req(sw_step_req),
  .sample(sample), .rst_err(rst_err), .step_err(step_err), .acc_q(acc_q)
);

// File: tb/sawtooth_gen_tb_top.sv
`timescale 1ns/1ps
module sawtooth_gen_tb_top;
  localparam int N_HW  = 3;
  localparam int SEL_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, step_dir = 1'b0;
  logic [11:0] rst_value = '0;
  logic [15:0] step_value = '0;
  logic [SEL_W-1:0] rst_src = '0, step_src = '0;
  logic sw_rst_req = 1'b0, sw_step_req = 1'b0;
  logic [N_HW-1:0] hw_rst_trig = '0, hw_step_trig = '0;
  logic [11:0] sample;
  logic rst_err, step_err;

  int n_run = 0, n_fail = 0;
  logic [15:0] model = '0;
  logic exp_rerr = 1'b0, exp_serr = 1'b0;

  always #2 clk = ~clk;

  sawtooth_gen #(.N_HW(N_HW), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .step_dir(step_dir),
    .rst_value(rst_value), .step_value(step_value),
    .rst_src(rst_src), .step_src(step_src),
    .sw_rst_req(sw_rst_req), .sw_step_req(sw_step_req),
    .hw_rst_trig(hw_rst_trig), .hw_step_trig(hw_step_trig),
    .sample(sample), .rst_err(rst_err), .step_err(step_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic pick(input logic [SEL_W-1:0] s, input logic sw,
                                input logic [N_HW-1:0] hw);
    if (s == 0) return sw;
    if (int'(s) <= N_HW) return hw[int'(s) - 1];
    return 1'b0;
  endfunction

  // One cycle: inputs are already set; update model, clock, check, clear strobes.
  task automatic tick(input string req);
    logic fr, fs;
    fr = en && pick(rst_src, sw_rst_req, hw_rst_trig);
    fs = en && pick(step_src, sw_step_req, hw_step_trig);
    exp_rerr = sw_rst_req && rst_src != 0;
    exp_serr = sw_step_req && step_src != 0;
    if (fr) model = {rst_value, 4'h0};
    else if (fs) model = step_dir ? model - step_value : model + step_value;
    @(negedge clk);
    check(req, {4'h0, sample}, {4'h0, model[15:4]});
    check({req, " err"}, {14'h0, rst_err, step_err}, {14'h0, exp_rerr, exp_serr});
    sw_rst_req = 0; sw_step_req = 0; hw_rst_trig = '0; hw_step_trig = '0;
  endtask

  task automatic restart(input logic [11:0] v, input string req);
    rst_src = 0; rst_value = v; sw_rst_req = 1; tick(req);
  endtask

  task automatic stepsw(input logic [15:0] s, input logic d, input string req);
    step_src = 0; step_value = s; step_dir = d; sw_step_req = 1; tick(req);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] steps [6];
    steps = '{16'h0001, 16'h0010, 16'h0FFF, 16'hFFFF, 16'h8008, 16'h0000};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 sample", {4'h0, sample}, 16'h0);
    check("R1 errs", {14'h0, rst_err, step_err}, 16'h0);
    en = 1;

    // R2: sweep restart levels
    for (int v = 0; v < 4096; v += 13) restart(12'(v), "R2");
    restart(12'hFFF, "R2 top");

    // R3 / R4: step sweeps in both directions
    for (int i = 0; i < 6; i++) begin
      restart(12'h7F3, "R2 pre");
      for (int n = 0; n < 40; n++) stepsw(steps[i], 1'b0, "R3 up sweep");
      for (int n = 0; n < 40; n++) stepsw(steps[i], 1'b1, "R4 down sweep");
    end

    // R3 wrap up, R4 wrap down
    restart(12'hFFF, "R2");
    stepsw(16'h0010, 1'b0, "R3 wrap");
    check("R3 wrap to 0", {4'h0, sample}, 16'h0);
    stepsw(16'h0010, 1'b1, "R4 wrap");
    check("R4 wrap to 4095", {4'h0, sample}, 16'h0FFF);

    // R9: fractional accumulation
    restart(12'h100, "R9 pre");
    for (int n = 1; n <= 16; n++) begin
      stepsw(16'h0001, 1'b0, "R9");
      check("R9 frac", {4'h0, sample}, (n == 16) ? 16'h101 : 16'h100);
    end

    // R5: simultaneous restart and step
    rst_src = 0; step_src = 0; rst_value = 12'h123; step_value = 16'h0500;
    step_dir = 0; sw_rst_req = 1; sw_step_req = 1;
    tick("R5");
    check("R5 restart wins", {4'h0, sample}, 16'h123);

    // R6: rejected software requests
    for (int s = 1; s < 4; s++) begin
      rst_src = SEL_W'(s); rst_value = 12'hABC; sw_rst_req = 1; tick("R6 rst reject");
      check("R6 held", {4'h0, sample}, 16'h123);
      check("R6 rst_err", {15'h0, rst_err}, 16'h1);
      step_src = SEL_W'(s); step_value = 16'h0100; sw_step_req = 1; tick("R6 step reject");
      check("R6 step_err", {15'h0, step_err}, 16'h1);
      tick("R6 one-cycle pulse");
      check("R6 err clear", {14'h0, rst_err, step_err}, 16'h0);
    end

    // R7: hardware lines, every select x every line pattern
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 8; p++) begin
        rst_src = SEL_W'(s); rst_value = 12'(16 * s + p + 1); hw_rst_trig = 3'(p);
        tick("R7 hw restart");
        step_src = SEL_W'(s); step_value = 16'h0230; step_dir = p[0];
        hw_step_trig = 3'(p); tick("R7 hw step");
      end

    // R8: disabled accumulator ignores everything, still flags errors
    restart(12'h055, "R8 pre");
    en = 0;
    stepsw(16'h0100, 1'b0, "R8 step ignored");
    restart(12'h3AA, "R8 restart ignored");
    rst_src = 1; hw_rst_trig = 3'b001; tick("R8 hw ignored");
    check("R8 held", {4'h0, sample}, 16'h055);
    step_src = 2; sw_step_req = 1; tick("R8 err still");
    en = 1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule